// File: doc/BRIEF.md
# Register Write Protection Guard

This block sits on a simple register bus between a processor and a bank of control registers. It owns one 8-bit guard control register and, based on three of its bits, suppresses writes to three independent groups of registers: pin configuration, interrupt control, and clocking/supply-monitor/parity control. Reads are never affected. A protected register therefore keeps its value even if runaway software keeps writing to it.

A parameter table gives the address and group code of each protected register. Addresses missing from the table are never protected. The pin data output register is deliberately left out of the default table, so it stays writable while the pin configuration around it is locked.

The guard control register itself is never protected, so software can always change the protection state. Every bus beat is accepted in the cycle it is presented, and the bus has no back-pressure. The write enable to the register bank is combinational, so an allowed write lands in the same cycle as the bus strobe. A rejected write raises a one-cycle pulse in the following cycle.

Top module: `regwr_guard`

## Requirements
- R1: After reset the guard control register reads 0x00, and a write to any table address reaches the bank.
- R2: A write to the guard address `CTL_ADDR` (default 0x78) stores data bits 7, 5, 4, 2, 1 and 0. Bits 6 and 3 always read 0, and a read at `CTL_ADDR` returns the stored value.
- R3: While guard bit 2 is 1, a write to an address whose table group code is 3 (pin configuration) leaves `reg_we` low.
- R4: While guard bit 1 is 1, a write to an address with group code 2 (interrupt control) leaves `reg_we` low.
- R5: While guard bit 0 is 1, a write to an address with group code 1 (clock/monitor/parity) leaves `reg_we` low.
- R6: A write to an address that is not in the table and is not `CTL_ADDR` drives `reg_we` high in the same cycle, whatever the guard bits are. The default pin data address 0x10 is one such address.
- R7: A read at any address other than `CTL_ADDR` drives `reg_re` high, and `bus_rdata` equals `reg_rdata` in the same cycle, whatever the guard bits are.
- R8: A write to `CTL_ADDR` is never blocked and never raises `reg_we` or `reg_re`.
- R9: `wr_blocked` is high for exactly the one cycle after a write that R3 to R5 suppressed, and low at all other times.
- R10: `reg_addr` and `reg_wdata` carry `bus_addr` and `bus_wdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | AW | Bus register address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data |
| reg_we | output | 1 | Write enable to the register bank |
| reg_re | output | 1 | Read enable to the register bank |
| reg_addr | output | AW | Address to the register bank |
| reg_wdata | output | 8 | Write data to the register bank |
| reg_rdata | input | 8 | Read data from the register bank |
| wr_blocked | output | 1 | One-cycle pulse after a suppressed write |

## Verification
Two of the block's functions can act in the same cycle. The first is the `wr_blocked` pulse left by a suppressed write. The second is the gating decision for the next beat, which may be a write that passes, a read, or a change to the guard register itself.

The bench sweeps every value of the three guard bits against every address, issuing a write beat and then a read beat, so each pulse coincides with a fresh gating decision. In each cycle it judges the pulse against the outcome the bench itself predicted for the previous beat. Separately, it judges `reg_we` and `bus_rdata` for the current beat against the group table and the guard value kept in the bench.

// File: rtl/regwr_guard_pkg.sv
`timescale 1ns/1ps
package regwr_guard_pkg;
  // Group codes held in the address table; code g is guarded by guard bit g-1
  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_CLK  = 2'd1,
    GRP_IRQ  = 2'd2,
    GRP_PORT = 2'd3
  } grp_e;

  localparam int GUARD_BITS = 3;
  localparam int DATA_W     = 8;
  // Writable bits of the guard control register (bits 6 and 3 fixed at zero)
  localparam logic [DATA_W-1:0] CTL_WMASK = 8'hB7;
endpackage

// File: rtl/regwr_guard_decode.sv
`timescale 1ns/1ps
module regwr_guard_decode
  import regwr_guard_pkg::*;
#(
  parameter int AW = 8,
  parameter int N  = 8,
  parameter logic [N*AW-1:0] TBL_ADDR = '0,
  parameter logic [N*2-1:0]  TBL_GRP  = '0
) (
  input  logic [AW-1:0]         addr,
  output logic [GUARD_BITS-1:0] grp_hit
);
  logic [N-1:0][GUARD_BITS-1:0] sel;

  for (genvar i = 0; i < N; i++) begin : g_entry
    logic match;
    assign match = (addr == TBL_ADDR[i*AW +: AW]);
    for (genvar g = 0; g < GUARD_BITS; g++) begin : g_grp
      assign sel[i][g] = match && (TBL_GRP[i*2 +: 2] == 2'(g + 1));
    end
  end

  always_comb begin
    grp_hit = '0;
    for (int i = 0; i < N; i++) grp_hit = grp_hit | sel[i];
  end
endmodule

// File: rtl/regwr_guard_ctl.sv
`timescale 1ns/1ps
module regwr_guard_ctl
  import regwr_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= wdata & CTL_WMASK;
  end
endmodule

// File: rtl/regwr_guard.sv
`timescale 1ns/1ps
module regwr_guard
  import regwr_guard_pkg::*;
#(
  parameter int AW = 8,
  parameter int N  = 8,
  parameter logic [AW-1:0]   CTL_ADDR = 8'h78,
  parameter logic [N*AW-1:0] TBL_ADDR =
    {8'h50, 8'h41, 8'h40, 8'h31, 8'h30, 8'h22, 8'h21, 8'h20},
  parameter logic [N*2-1:0]  TBL_GRP  =
    {GRP_CLK, GRP_CLK, GRP_CLK, GRP_IRQ, GRP_IRQ, GRP_PORT, GRP_PORT, GRP_PORT}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          reg_we,
  output logic          reg_re,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  input  logic [7:0]    reg_rdata,
  output logic          wr_blocked
);
  logic                  is_ctl;
  logic [DATA_W-1:0]     ctl_q;
  logic [GUARD_BITS-1:0] grp_hit;
  logic                  guarded;
  logic                  blk_q;

  assign is_ctl = (bus_addr == CTL_ADDR);

  regwr_guard_ctl u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bus_wr && is_ctl),
    .wdata (bus_wdata),
    .ctl_q (ctl_q)
  );

  regwr_guard_decode #(
    .AW(AW), .N(N), .TBL_ADDR(TBL_ADDR), .TBL_GRP(TBL_GRP)
  ) u_dec (
    .addr    (bus_addr),
    .grp_hit (grp_hit)
  );

  assign guarded   = |(grp_hit & ctl_q[GUARD_BITS-1:0]);
  assign reg_we    = bus_wr && !is_ctl && !guarded;
  assign reg_re    = bus_rd && !is_ctl;
  assign reg_addr  = bus_addr;
  assign reg_wdata = bus_wdata;
  assign bus_rdata = is_ctl ? ctl_q : reg_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_q <= 1'b0;
    else        blk_q <= bus_wr && !is_ctl && guarded;
  end
  assign wr_blocked = blk_q;
endmodule

// File: rtl/regwr_guard_chk.sv
`timescale 1ns/1ps
module regwr_guard_chk #(
  parameter int AW = 8,
  parameter logic [AW-1:0] CTL_ADDR = 8'h78
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_rdata,
  input logic [7:0]    reg_rdata,
  input logic          reg_we,
  input logic          reg_re,
  input logic          wr_blocked
);
  assert_ctl_fixed_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == CTL_ADDR) |-> (!bus_rdata[6] && !bus_rdata[3]));

  assert_read_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != CTL_ADDR) |-> (reg_re && bus_rdata == reg_rdata));

  assert_ctl_never_to_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CTL_ADDR) |-> (!reg_we && !reg_re));

  assert_we_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> bus_wr);

  assert_pulse_after_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != CTL_ADDR && !reg_we) |=> wr_blocked);

  assert_pulse_only_after_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |-> $past(bus_wr && bus_addr != CTL_ADDR && !reg_we));
endmodule

bind regwr_guard regwr_guard_chk #(.AW(AW), .CTL_ADDR(CTL_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .reg_rdata  (reg_rdata),
  .reg_we     (reg_we),
  .reg_re     (reg_re),
  .wr_blocked (wr_blocked)
);

// File: tb/regwr_guard_test.sv
`timescale 1ns/1ps
module regwr_guard_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic       reg_we, reg_re, wr_blocked;
  logic [7:0] reg_addr, reg_wdata;
  logic [7:0] reg_rdata = '0;

  int checks = 0;
  int fails  = 0;
  logic [7:0] ctl_model = '0;
  logic       exp_blk = 1'b0;
  bit         done = 1'b0;

  localparam logic [7:0] CTL = 8'h78;

  always #5 clk = ~clk;

  regwr_guard uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_blocked(wr_blocked)
  );

  // Group mask from the specified default table: bit0 clock, bit1 irq, bit2 port
  function automatic logic [2:0] grp_mask(input logic [7:0] a);
    case (a)
      8'h20, 8'h21, 8'h22: return 3'b100;
      8'h30, 8'h31:        return 3'b010;
      8'h40, 8'h41, 8'h50: return 3'b001;
      default:             return 3'b000;
    endcase
  endfunction

  function automatic string grp_tag(input logic [7:0] a);
    case (grp_mask(a))
      3'b100:  return "R3";
      3'b010:  return "R4";
      3'b001:  return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic beat(input logic w, input logic r, input logic [7:0] a, input logic [7:0] d);
    logic ctl, blk;
    @(negedge clk);
    chk(wr_blocked == exp_blk, "R9", wr_blocked, exp_blk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; reg_rdata = ~a;
    #1;
    ctl = (a == CTL);
    blk = w && !ctl && |(grp_mask(a) & ctl_model[2:0]);
    if (w && !ctl) begin
      chk(reg_we == !blk, grp_tag(a), reg_we, !blk);
      chk(reg_addr == a && reg_wdata == d, "R10", {reg_addr, reg_wdata}, {a, d});
    end
    if (ctl) chk(!reg_we && !reg_re, "R8", {reg_we, reg_re}, 0);
    if (r && !ctl) chk(reg_re && bus_rdata == ~a, "R7", {reg_re, bus_rdata}, {1'b1, ~a});
    if (r && ctl) chk(bus_rdata == ctl_model, "R2", bus_rdata, ctl_model);
    if (w && ctl) ctl_model = d & 8'hB7;
    exp_blk = blk;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wr_blocked == 1'b0, "R1", wr_blocked, 0);
    rst_n = 1'b1;
    // R1: control reads zero and guarded-table writes pass after reset
    beat(1'b0, 1'b1, CTL, 8'h00);
    beat(1'b1, 1'b0, 8'h20, 8'h5A);
    beat(1'b1, 1'b0, 8'h31, 8'hA5);
    beat(1'b1, 1'b0, 8'h50, 8'h3C);
    // R2: every control data value, read back
    for (int v = 0; v < 256; v++) begin
      beat(1'b1, 1'b0, CTL, 8'(v));
      beat(1'b0, 1'b1, CTL, 8'h00);
    end
    // R3..R7, R9: all guard settings against all addresses, write then read
    for (int g = 0; g < 8; g++) begin
      beat(1'b1, 1'b0, CTL, 8'(g) | 8'hB0);
      for (int a = 0; a < 256; a++) begin
        if (8'(a) == CTL) continue;
        beat(1'b1, 1'b0, 8'(a), 8'(a) ^ 8'(g));
        beat(1'b0, 1'b1, 8'(a), 8'h00);
      end
      // blocked write directly followed by guard change (R8, R9)
      beat(1'b1, 1'b0, 8'h21, 8'hFF);
      beat(1'b1, 1'b0, CTL, 8'h00);
      beat(1'b1, 1'b0, 8'h21, 8'hEE);
    end
    // simultaneous read and write to guarded address (R7, R5)
    beat(1'b1, 1'b0, CTL, 8'h07);
    beat(1'b1, 1'b1, 8'h40, 8'h11);
    beat(1'b1, 1'b1, 8'h10, 8'h22);
    beat(1'b0, 1'b0, 8'h00, 8'h00);
    beat(1'b0, 1'b0, 8'h00, 8'h00);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule